// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Pipeline Sequencer

This block steps instructions for a 32-bit RISC core through three one-cycle stages: fetch, decode and execute. It holds the fetch address, drives it to an instruction memory that answers in the same cycle, and moves each returned word through a decode slot and an execute slot. Each slot carries its own valid bit and the instruction mode that was in force when the word was fetched. Once the pipeline is full, one instruction reaches execute in every unstalled cycle.

Execute is also given the program-counter value that its instruction reads. This value is ahead of the instruction's own address by the depth of the pipeline. The distance is 8 bytes for full-width instructions and 4 bytes for compressed ones.

The surrounding core reports taken branches and PC writes from the execute stage. The block then empties decode and execute and restarts fetch at the new address. An interrupt request is held pending until a cycle in which it can be taken without cutting short the instruction in execute. When it is taken, the block saves a return address and restarts fetch at a fixed vector. Decoding, the ALU, the register file and data memory lie outside this block.

Top module: `pipe_seq3`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `imem_addr` is 0, `dec_valid`, `ex_valid` and `irq_ack` are 0, and fetch starts in full-width mode.
- R2: In an unstalled cycle with no redirect, decode captures the fetched word (`imem_rdata`) and `imem_addr`, and execute captures the contents of decode. The bench's memory returns `addr ^ 32'hC3C3_0000`, and `ex_word` must match that for `ex_addr`.
- R3: In an unstalled cycle with no redirect, the fetch address advances by 4 when `cmp_mode` is 0 (full-width) and by 2 when `cmp_mode` is 1 (compressed).
- R4: `ex_pc` equals `ex_addr + 8` for an instruction fetched with `cmp_mode` = 0, and `ex_addr + 4` for one fetched with `cmp_mode` = 1. The mode recorded at fetch is used even if `cmp_mode` changes later.
- R5: When `ex_valid` is 1 and either `br_taken` or `pc_wr` is 1, the next cycle shows `dec_valid` = 0, `ex_valid` = 0 and `imem_addr` at the new target. The target is `pc_wr_val` if `pc_wr` is 1, and `br_target` otherwise.
- R6: After such a redirect, with no stall, execute shows two cycles with `ex_valid` = 0, and the target instruction is in execute in the third cycle.
- R7: `br_taken` and `pc_wr` have no effect in a cycle where `ex_valid` is 0.
- R8: While `stall` is 1 and no redirect occurs, `imem_addr`, the decode slot and the execute slot keep their values.
- R9: A branch or PC-write redirect takes effect even while `stall` is 1.
- R10: A pending interrupt is taken at the end of the first cycle that has no stall and no branch/PC-write redirect. The instruction in execute in that cycle completes. In the next cycle `irq_ack` is 1 for one cycle and `imem_addr` is the vector (default `32'h18`). `irq_ret` holds the address of the oldest unexecuted instruction: the decode address if decode is valid, and the fetch address otherwise.
- R11: A branch/PC-write redirect in the same cycle as an interrupt request wins. The interrupt is taken one cycle later with `irq_ret` equal to the redirect target.
- R12: An interrupt requested during a stall stays pending, and is taken in the first unstalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold all pipeline state for this cycle |
| cmp_mode | input | 1 | 1 = compressed instructions, 0 = full-width |
| imem_addr | output | 32 | Fetch address to instruction memory |
| imem_rdata | input | 32 | Instruction word returned in the same cycle |
| dec_valid | output | 1 | Decode slot holds an instruction |
| dec_addr | output | 32 | Address of the decode instruction |
| dec_word | output | 32 | Word in the decode slot |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_addr | output | 32 | Address of the execute instruction |
| ex_word | output | 32 | Word in the execute slot |
| ex_pc | output | 32 | PC value read by the execute instruction |
| br_taken | input | 1 | Execute instruction is a taken branch |
| br_target | input | 32 | Branch destination |
| pc_wr | input | 1 | Execute instruction writes the PC |
| pc_wr_val | input | 32 | Value written to the PC |
| irq_req | input | 1 | Interrupt request pulse |
| irq_ack | output | 1 | One-cycle pulse on interrupt entry |
| irq_ret | output | 32 | Saved return address |

## Verification
The assertions assume that `br_taken` and `pc_wr` come from the execute stage, and that `irq_req` is a single-cycle pulse that is not raised again before `irq_ack`. They also assume that the instruction memory answers within the same cycle. The stimulus drives the redirect inputs only in cycles whose `ex_valid` is known from the table or the directed sequence, with one exception. That exception is a cycle where a branch is raised on purpose while `ex_valid` is 0. The stimulus pulses the interrupt request once per test, so an entry is never followed by a retake.

// File: rtl/ps3_pkg.sv
package ps3_pkg;
    localparam int XLEN = 32;

    typedef struct packed {
        logic            valid;
        logic            cmode;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] word;
    } slot_t;

    typedef struct packed {
        logic [XLEN-1:0] addr;
    } fetch_st_t;

    typedef struct packed {
        logic            pend;
        logic            ack;
        logic [XLEN-1:0] ret;
    } ctrl_st_t;
endpackage

// File: rtl/ps3_fetch.sv
module ps3_fetch
    import ps3_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC  = '0,
    parameter int              STEP_FULL = 4,
    parameter int              STEP_HALF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            load,
    input  logic [XLEN-1:0] load_addr,
    input  logic            cmode,
    output logic [XLEN-1:0] addr
);
    fetch_st_t st_d, st_q;
    logic [XLEN-1:0] step;

    always_comb begin
        st_d = st_q;
        step = cmode ? XLEN'(STEP_HALF) : XLEN'(STEP_FULL);
        if (load) begin
            st_d.addr = load_addr;
        end else if (!hold) begin
            st_d.addr = st_q.addr + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.addr;
endmodule

// File: rtl/ps3_slot.sv
module ps3_slot
    import ps3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  kill,
    input  slot_t din,
    output slot_t q
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (kill) begin
            slot_d.valid = 1'b0;
        end else if (!hold) begin
            slot_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign q = slot_q;
endmodule

// File: rtl/ps3_ctrl.sv
module ps3_ctrl
    import ps3_pkg::*;
#(
    parameter logic [XLEN-1:0] IRQ_VEC = 32'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            ex_valid,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic            pc_wr,
    input  logic [XLEN-1:0] pc_wr_val,
    input  logic            irq_req,
    input  logic            dec_valid,
    input  logic [XLEN-1:0] dec_addr,
    input  logic [XLEN-1:0] fetch_addr,
    output logic            flush,
    output logic [XLEN-1:0] redir_addr,
    output logic            irq_ack,
    output logic [XLEN-1:0] irq_ret
);
    ctrl_st_t st_d, st_q;
    logic jump;
    logic want;
    logic take;

    always_comb begin
        st_d = st_q;
        jump = ex_valid && (br_taken || pc_wr);
        want = st_q.pend || irq_req;
        take = want && !stall && !jump;

        flush = jump || take;
        if (jump) begin
            redir_addr = pc_wr ? pc_wr_val : br_target;
        end else begin
            redir_addr = IRQ_VEC;
        end

        st_d.pend = want && !take;
        st_d.ack  = take;
        if (take) begin
            st_d.ret = dec_valid ? dec_addr : fetch_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_ack = st_q.ack;
    assign irq_ret = st_q.ret;
endmodule

// File: rtl/pipe_seq3.sv
module pipe_seq3
    import ps3_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC  = '0,
    parameter logic [XLEN-1:0] IRQ_VEC   = 32'h18,
    parameter int              STEP_FULL = 4,
    parameter int              STEP_HALF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            cmp_mode,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic            dec_valid,
    output logic [XLEN-1:0] dec_addr,
    output logic [XLEN-1:0] dec_word,
    output logic            ex_valid,
    output logic [XLEN-1:0] ex_addr,
    output logic [XLEN-1:0] ex_word,
    output logic [XLEN-1:0] ex_pc,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic            pc_wr,
    input  logic [XLEN-1:0] pc_wr_val,
    input  logic            irq_req,
    output logic            irq_ack,
    output logic [XLEN-1:0] irq_ret
);
    localparam int NSLOT    = 2;
    localparam int OFS_FULL = 2 * STEP_FULL;
    localparam int OFS_HALF = 2 * STEP_HALF;

    logic            flush;
    logic [XLEN-1:0] redir_addr;
    logic [XLEN-1:0] fetch_addr;
    slot_t           slot_in [NSLOT];
    slot_t           slot_q  [NSLOT];

    ps3_fetch #(
        .RESET_PC (RESET_PC),
        .STEP_FULL(STEP_FULL),
        .STEP_HALF(STEP_HALF)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stall),
        .load     (flush),
        .load_addr(redir_addr),
        .cmode    (cmp_mode),
        .addr     (fetch_addr)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g == 0) begin : g_head
            assign slot_in[g] = '{valid: 1'b1, cmode: cmp_mode,
                                  addr: fetch_addr, word: imem_rdata};
        end else begin : g_tail
            assign slot_in[g] = slot_q[g-1];
        end
        ps3_slot u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (stall),
            .kill (flush),
            .din  (slot_in[g]),
            .q    (slot_q[g])
        );
    end

    ps3_ctrl #(
        .IRQ_VEC(IRQ_VEC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .ex_valid  (slot_q[NSLOT-1].valid),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pc_wr     (pc_wr),
        .pc_wr_val (pc_wr_val),
        .irq_req   (irq_req),
        .dec_valid (slot_q[0].valid),
        .dec_addr  (slot_q[0].addr),
        .fetch_addr(fetch_addr),
        .flush     (flush),
        .redir_addr(redir_addr),
        .irq_ack   (irq_ack),
        .irq_ret   (irq_ret)
    );

    assign imem_addr = fetch_addr;
    assign dec_valid = slot_q[0].valid;
    assign dec_addr  = slot_q[0].addr;
    assign dec_word  = slot_q[0].word;
    assign ex_valid  = slot_q[NSLOT-1].valid;
    assign ex_addr   = slot_q[NSLOT-1].addr;
    assign ex_word   = slot_q[NSLOT-1].word;
    assign ex_pc     = slot_q[NSLOT-1].addr +
                       (slot_q[NSLOT-1].cmode ? XLEN'(OFS_HALF) : XLEN'(OFS_FULL));
endmodule

// File: rtl/ps3_chk.sv
module ps3_chk
    import ps3_pkg::*;
#(
    parameter logic [XLEN-1:0] IRQ_VEC = 32'h18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            cmp_mode,
    input logic [XLEN-1:0] imem_addr,
    input logic            dec_valid,
    input logic [XLEN-1:0] dec_addr,
    input logic            ex_valid,
    input logic [XLEN-1:0] ex_addr,
    input logic            br_taken,
    input logic            pc_wr,
    input logic            irq_ack,
    input logic            flush,
    input logic [XLEN-1:0] redir_addr
);
    p_flush_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dec_valid && !ex_valid));

    p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (imem_addr == $past(redir_addr)));

    p_two_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 (!stall && !flush)) |=> !ex_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> ($stable(imem_addr) && $stable(ex_valid) &&
                               $stable(ex_addr) && $stable(dec_addr)));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush && dec_valid) |=> (ex_valid && ex_addr == $past(dec_addr)));

    p_step_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush && !cmp_mode) |=> (imem_addr == $past(imem_addr) + 32'd4));

    p_step_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush && cmp_mode) |=> (imem_addr == $past(imem_addr) + 32'd2));

    p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (br_taken || pc_wr)) |=> !irq_ack);

    p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (imem_addr == IRQ_VEC && !ex_valid));
endmodule

bind pipe_seq3 ps3_chk #(.IRQ_VEC(IRQ_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .cmp_mode  (cmp_mode),
    .imem_addr (imem_addr),
    .dec_valid (dec_valid),
    .dec_addr  (dec_addr),
    .ex_valid  (ex_valid),
    .ex_addr   (ex_addr),
    .br_taken  (br_taken),
    .pc_wr     (pc_wr),
    .irq_ack   (irq_ack),
    .flush     (flush),
    .redir_addr(redir_addr)
);

// File: tb/tb_pipe_seq3.sv
module tb_pipe_seq3;
    localparam logic [31:0] KEY = 32'hC3C3_0000;
    localparam logic [31:0] VEC = 32'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        cmp_mode = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        dec_valid;
    logic [31:0] dec_addr;
    logic [31:0] dec_word;
    logic        ex_valid;
    logic [31:0] ex_addr;
    logic [31:0] ex_word;
    logic [31:0] ex_pc;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        pc_wr = 1'b0;
    logic [31:0] pc_wr_val = '0;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic [31:0] irq_ret;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign imem_rdata = imem_addr ^ KEY;

    pipe_seq3 dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .cmp_mode(cmp_mode),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_word(dec_word),
        .ex_valid(ex_valid), .ex_addr(ex_addr), .ex_word(ex_word), .ex_pc(ex_pc),
        .br_taken(br_taken), .br_target(br_target),
        .pc_wr(pc_wr), .pc_wr_val(pc_wr_val),
        .irq_req(irq_req), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    typedef struct packed {
        logic        st;
        logic        cm;
        logic        br;
        logic        pw;
        logic        irq;
        logic [31:0] tgt;
        logic [31:0] e_fa;
        logic        e_xv;
        logic [31:0] e_xa;
        logic [31:0] e_pc;
        logic        e_ack;
        logic [31:0] e_ret;
    } row_t;

    // Per cycle: stimulus, then outputs expected in that same cycle.
    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h0,  1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h4,  1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h8,  1'b1,32'h0,  32'h8,  1'b0,32'h0},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h40,  32'hC,  1'b1,32'h4,  32'hC,  1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h40, 1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h44, 1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h48, 1'b1,32'h40, 32'h48, 1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,   32'h48, 1'b1,32'h40, 32'h48, 1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,   32'h4A, 1'b1,32'h44, 32'h4C, 1'b0,32'h0},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,32'h80,  32'h4C, 1'b1,32'h48, 32'h4C, 1'b0,32'h0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h300, 32'h180,1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,   32'h182,1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,   32'h184,1'b1,32'h180,32'h184,1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h18, 1'b0,32'h0,  32'h0,  1'b1,32'h182},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1C, 1'b0,32'h0,  32'h0,  1'b0,32'h0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h20, 1'b1,32'h18, 32'h20, 1'b0,32'h0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        stall = 1'b0; br_taken = 1'b0; pc_wr = 1'b0; irq_req = 1'b0;
        br_target = '0; pc_wr_val = '0; cmp_mode = 1'b0;
    endtask

    task automatic do_reset();
        quiet();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "imem_addr in reset", imem_addr, 32'h0);
        chk("R1", "ex_valid in reset", {31'b0, ex_valid}, 32'h0);
        chk("R1", "dec_valid in reset", {31'b0, dec_valid}, 32'h0);
        chk("R1", "irq_ack in reset", {31'b0, irq_ack}, 32'h0);
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 first cycle, R2 flow, R3 step, R4 pc view,
        // R5/R6 redirect and bubbles, R7 ignored branch, R8 stall, R10 interrupt.
        for (int i = 0; i < NROW; i++) begin
            chk("R3", $sformatf("row%0d imem_addr", i), imem_addr, TBL[i].e_fa);
            chk("R6", $sformatf("row%0d ex_valid", i), {31'b0, ex_valid}, {31'b0, TBL[i].e_xv});
            chk("R10", $sformatf("row%0d irq_ack", i), {31'b0, irq_ack}, {31'b0, TBL[i].e_ack});
            if (TBL[i].e_xv) begin
                chk("R2", $sformatf("row%0d ex_addr", i), ex_addr, TBL[i].e_xa);
                chk("R2", $sformatf("row%0d ex_word", i), ex_word, TBL[i].e_xa ^ KEY);
                chk("R4", $sformatf("row%0d ex_pc", i), ex_pc, TBL[i].e_pc);
            end
            if (TBL[i].e_ack) begin
                chk("R10", $sformatf("row%0d irq_ret", i), irq_ret, TBL[i].e_ret);
            end
            stall     = TBL[i].st;
            cmp_mode  = TBL[i].cm;
            br_taken  = TBL[i].br;
            pc_wr     = TBL[i].pw;
            irq_req   = TBL[i].irq;
            br_target = TBL[i].tgt;
            pc_wr_val = TBL[i].tgt + 32'h100;
            tick();
        end

        // R11: branch and interrupt in the same cycle.
        do_reset();
        repeat (3) tick();
        chk("R11", "ex_valid before", {31'b0, ex_valid}, 32'h1);
        br_taken = 1'b1; br_target = 32'h200; irq_req = 1'b1;
        tick();
        br_taken = 1'b0; irq_req = 1'b0;
        chk("R11", "fetch at branch target", imem_addr, 32'h200);
        chk("R11", "no ack with branch", {31'b0, irq_ack}, 32'h0);
        tick();
        chk("R11", "deferred ack", {31'b0, irq_ack}, 32'h1);
        chk("R11", "vector fetch", imem_addr, VEC);
        chk("R11", "return is target", irq_ret, 32'h200);
        tick();
        chk("R10", "ack is one cycle", {31'b0, irq_ack}, 32'h0);

        // R9: redirect during stall, then R8 hold.
        do_reset();
        repeat (2) tick();
        chk("R9", "ex_valid before", {31'b0, ex_valid}, 32'h1);
        stall = 1'b1; br_taken = 1'b1; br_target = 32'h60;
        tick();
        br_taken = 1'b0;
        chk("R9", "fetch redirected in stall", imem_addr, 32'h60);
        chk("R9", "ex flushed in stall", {31'b0, ex_valid}, 32'h0);
        chk("R9", "dec flushed in stall", {31'b0, dec_valid}, 32'h0);
        tick();
        chk("R8", "fetch held in stall", imem_addr, 32'h60);
        stall = 1'b0;
        tick();
        chk("R8", "fetch resumes", imem_addr, 32'h64);
        chk("R2", "dec takes target", dec_addr, 32'h60);
        chk("R2", "dec word", dec_word, 32'h60 ^ KEY);

        // R12: interrupt raised while stalled.
        do_reset();
        repeat (2) tick();
        stall = 1'b1; irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        chk("R12", "no ack in stall", {31'b0, irq_ack}, 32'h0);
        chk("R12", "fetch held", imem_addr, 32'h8);
        tick();
        chk("R12", "still no ack", {31'b0, irq_ack}, 32'h0);
        stall = 1'b0;
        tick();
        chk("R12", "ack after stall", {31'b0, irq_ack}, 32'h1);
        chk("R12", "vector fetch", imem_addr, VEC);
        chk("R12", "return is decode addr", irq_ret, 32'h4);

        // R1: reset in the middle of activity.
        repeat (3) tick();
        do_reset();
        chk("R1", "first cycle fetch", imem_addr, 32'h0);
        chk("R1", "first cycle ex_valid", {31'b0, ex_valid}, 32'h0);
        tick();
        chk("R3", "full-width step after reset", imem_addr, 32'h4);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule